// File: doc/BRIEF.md
# Interrupt Line State Register Block

This block keeps the per-line state of a bank-organised interrupt distributor. For each implemented interrupt line it stores an enable bit, a pending bit, an active bit, an 8-bit priority and a trigger mode (level or edge). Software reaches this state through a word register bus with byte strobes. Enable and pending bits are changed through separate write-one-to-set and write-one-to-clear windows, so a write never needs a read-modify-write. Lines that the chip does not implement are tied to zero. Software can find the lines that exist by writing all ones to the enable windows and reading the result back.

Raw interrupt inputs feed the pending logic. A level line is pending while its input is high. An edge line latches on a rising input. A downstream CPU interface reads the enable, pending and priority vectors and the global forward-enable. It reports an acknowledge, which moves a line from pending to active, and an end-of-interrupt, which retires the active state. The line count is a parameter that must be a multiple of 32, and the default is 64. The set of implemented lines is given by a mask parameter. Lines 0 to 15 are reserved for software-generated interrupts and always act as edge lines.

Top module: `dist_regs`

## Requirements
- R1: After reset every line is disabled, not pending and not active, with priority 0. The control register reads 0. Lines 16 and up read as level-sensitive, and lines 0 to 15 read as edge.
- R2: The control word at byte offset 0x000 stores bit 0, the global forward-enable driven on `fwd_en_o`, and bit 1, a stored second enable. Both are written under strobe 0 and read back, and all other bits read 0.
- R3: The word at 0x004 is read-only. Bits [4:0] hold line count/32 − 1 and bits [7:5] hold CPU count − 1, so the default reads 0x21. Writes to it change nothing.
- R4: Writing a 1 to bit k of the word at 0x100 + 4·b enables line 32·b + k. A 0 has no effect, and only byte lanes with their strobe set take part. A read returns the enable bits of bank b.
- R5: Writing a 1 to bit k of the word at 0x180 + 4·b disables line 32·b + k. A read there returns the same enable bits as the set window.
- R6: An unimplemented line never holds enable, pending, active, priority or edge state. All of these read 0 even after writes of all ones.
- R7: The words at 0x200 + 4·b and 0x280 + 4·b set and clear pending with write-one semantics. These writes are ignored for lines 0 to 15 and for level lines.
- R8: A level line's pending bit equals its input as sampled on the previous clock edge.
- R9: On an edge line, a rising input or a set-pending write makes pending 1. It stays 1 until a clear-pending write or an acknowledge of that line. When a set and a clear come in the same cycle, the set wins.
- R10: With `ack_valid` high, line `ack_id` becomes active and, if it is an edge line, stops pending. With `eoi_valid` high, line `eoi_id` stops being active, but an acknowledge in the same cycle for the same line wins. Active bits read at 0x300 + 4·b, and writes there change nothing.
- R11: Line n's priority is byte n%4 of the word at 0x400 + 4·(n/4). All 8 bits are stored, and each byte is written only under its own strobe.
- R12: The word at 0xC00 + 4·(n/16) carries line n's mode in bit 2·(n%16)+1, where 1 means edge and 0 means level. Even bits read 0. Lines 0 to 15 ignore mode writes and read 1.
- R13: `enab_o`, `pend_o` and `prio_o` show the stored enable, pending and priority state one cycle after the write or input that changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe for the addressed word |
| bus_waddr | input | 10 | Word address (byte offset / 4) |
| bus_be | input | 4 | Byte lane strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr`, combinational |
| irq_in | input | N_LINES | Raw interrupt inputs |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Acknowledged line |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | ID_W | Retired line |
| fwd_en_o | output | 1 | Global forward-enable |
| enab_o | output | N_LINES | Per-line enable |
| pend_o | output | N_LINES | Per-line pending |
| prio_o | output | 8·N_LINES | Per-line priority, line n at bits [8n+7:8n] |

## Verification
A wrong enable, pending or priority bit shows up on the output vectors one cycle after the write, input change or acknowledge that should have set it. The bench compares these vectors with its model on every cycle, so such an error is caught on that cycle. Mode and active bits do not reach any output vector, and an error in them stays hidden until it changes a later pending update or a register read returns it. Reads spread over all windows during random traffic bring these bits to the ports within a few hundred cycles.

// File: rtl/dist_regs_pkg.sv
package dist_regs_pkg;

    localparam int LINES_PER_BANK = 32;
    localparam int SW_LINES       = 16;
    localparam int WORD_AW        = 10;

    // byte offsets of the register windows
    localparam logic [11:0] OFS_CTRL   = 12'h000;
    localparam logic [11:0] OFS_TYPE   = 12'h004;
    localparam logic [11:0] OFS_EN_SET = 12'h100;
    localparam logic [11:0] OFS_EN_CLR = 12'h180;
    localparam logic [11:0] OFS_PD_SET = 12'h200;
    localparam logic [11:0] OFS_PD_CLR = 12'h280;
    localparam logic [11:0] OFS_ACTIVE = 12'h300;
    localparam logic [11:0] OFS_PRIO   = 12'h400;
    localparam logic [11:0] OFS_CFG    = 12'hC00;

    typedef struct packed {
        logic ns_en;
        logic fwd_en;
    } ctrl_t;

    function automatic logic [31:0] strobe_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] sw_line_mask(input int base_id);
        logic [31:0] m;
        for (int j = 0; j < LINES_PER_BANK; j++) begin
            m[j] = (base_id + j) < SW_LINES;
        end
        return m;
    endfunction

endpackage

// File: rtl/dist_line_bank.sv
module dist_line_bank
    import dist_regs_pkg::*;
#(
    parameter int          BASE_ID = 0,
    parameter logic [31:0] IMPL    = '1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] irq_i,
    input  logic [31:0] en_set_i,
    input  logic [31:0] en_clr_i,
    input  logic [31:0] pd_set_i,
    input  logic [31:0] pd_clr_i,
    input  logic [31:0] cfg_we_i,
    input  logic [31:0] cfg_val_i,
    input  logic [31:0] ack_i,
    input  logic [31:0] eoi_i,
    output logic [31:0] en_o,
    output logic [31:0] pend_o,
    output logic [31:0] act_o,
    output logic [31:0] edge_o
);

    localparam logic [31:0] SW_MASK = sw_line_mask(BASE_ID);

    typedef struct packed {
        logic [31:0] en;
        logic [31:0] pend;
        logic [31:0] act;
        logic [31:0] edge_cfg;
        logic [31:0] irq_prev;
    } bank_st_t;

    bank_st_t    st_d, st_q;
    logic [31:0] eff_edge;
    logic [31:0] rise_v;
    logic [31:0] pset_v;
    logic [31:0] pclr_v;
    logic [31:0] cfg_wr_v;

    assign eff_edge = SW_MASK | st_q.edge_cfg;
    assign rise_v   = irq_i & ~st_q.irq_prev;
    assign pset_v   = rise_v | (pd_set_i & ~SW_MASK);
    assign pclr_v   = (pd_clr_i & ~SW_MASK) | ack_i;
    assign cfg_wr_v = cfg_we_i & ~SW_MASK;

    always_comb begin
        st_d          = st_q;
        st_d.en       = (st_q.en | en_set_i) & ~en_clr_i & IMPL;
        st_d.edge_cfg = ((st_q.edge_cfg & ~cfg_wr_v) | (cfg_val_i & cfg_wr_v)) & IMPL;
        // edge lines latch, level lines follow the input
        st_d.pend     = ((eff_edge & (pset_v | (st_q.pend & ~pclr_v)))
                        | (~eff_edge & irq_i)) & IMPL;
        st_d.act      = (ack_i | (st_q.act & ~eoi_i)) & IMPL;
        st_d.irq_prev = irq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign act_o  = st_q.act;
    assign edge_o = eff_edge & IMPL;

endmodule

// File: rtl/dist_prio_array.sv
module dist_prio_array #(
    parameter int                 N_LINES = 64,
    parameter logic [N_LINES-1:0] IMPL    = '1,
    parameter int                 PRIO_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_LINES-1:0]          we_i,
    input  logic [N_LINES*PRIO_W-1:0]   wdata_i,
    output logic [N_LINES*PRIO_W-1:0]   prio_o
);

    logic [N_LINES*PRIO_W-1:0] prio_d, prio_q;

    always_comb begin
        prio_d = prio_q;
        for (int i = 0; i < N_LINES; i++) begin
            if (we_i[i] && IMPL[i]) begin
                prio_d[i*PRIO_W +: PRIO_W] = wdata_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else begin
            prio_q <= prio_d;
        end
    end

    assign prio_o = prio_q;

endmodule

// File: rtl/dist_regs.sv
module dist_regs
    import dist_regs_pkg::*;
#(
    parameter int                 N_LINES = 64,
    parameter int                 N_CPUS  = 2,
    parameter logic [N_LINES-1:0] IMPL    = 64'hFFFF_00FF_FFFF_FFFF,
    localparam int                ID_W    = $clog2(N_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wen,
    input  logic [9:0]             bus_waddr,
    input  logic [3:0]             bus_be,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [N_LINES-1:0]     irq_in,
    input  logic                   ack_valid,
    input  logic [ID_W-1:0]        ack_id,
    input  logic                   eoi_valid,
    input  logic [ID_W-1:0]        eoi_id,
    output logic                   fwd_en_o,
    output logic [N_LINES-1:0]     enab_o,
    output logic [N_LINES-1:0]     pend_o,
    output logic [N_LINES*8-1:0]   prio_o
);

    localparam int NB          = N_LINES / LINES_PER_BANK;
    localparam int PRIO_WORDS  = N_LINES / 4;
    localparam int CFG_WORDS   = N_LINES / 16;
    localparam logic [WORD_AW-1:0] WA_CTRL   = WORD_AW'(OFS_CTRL >> 2);
    localparam logic [WORD_AW-1:0] WA_TYPE   = WORD_AW'(OFS_TYPE >> 2);
    localparam logic [WORD_AW-1:0] WA_EN_SET = WORD_AW'(OFS_EN_SET >> 2);
    localparam logic [WORD_AW-1:0] WA_EN_CLR = WORD_AW'(OFS_EN_CLR >> 2);
    localparam logic [WORD_AW-1:0] WA_PD_SET = WORD_AW'(OFS_PD_SET >> 2);
    localparam logic [WORD_AW-1:0] WA_PD_CLR = WORD_AW'(OFS_PD_CLR >> 2);
    localparam logic [WORD_AW-1:0] WA_ACTIVE = WORD_AW'(OFS_ACTIVE >> 2);
    localparam logic [WORD_AW-1:0] WA_PRIO   = WORD_AW'(OFS_PRIO >> 2);
    localparam logic [WORD_AW-1:0] WA_CFG    = WORD_AW'(OFS_CFG >> 2);
    localparam logic [31:0] TYPE_WORD = {24'd0, 3'(N_CPUS - 1), 5'(NB - 1)};

    typedef struct packed {
        ctrl_t ctrl;
    } top_st_t;

    top_st_t              st_d, st_q;
    logic [31:0]          wmask;
    logic [N_LINES-1:0]   en_set, en_clr, pd_set, pd_clr;
    logic [N_LINES-1:0]   cfg_we, cfg_val, prio_we, ack_hit, eoi_hit;
    logic [N_LINES*8-1:0] prio_wd;
    logic [N_LINES-1:0]   en_all, pend_all, act_all, edge_all;
    logic [N_LINES*8-1:0] prio_all;

    // write decode
    always_comb begin
        wmask  = strobe_mask(bus_be);
        en_set = '0;
        en_clr = '0;
        pd_set = '0;
        pd_clr = '0;
        for (int b = 0; b < NB; b++) begin
            if (bus_wen && bus_waddr == WORD_AW'(WA_EN_SET + b)) en_set[b*32 +: 32] = bus_wdata & wmask;
            if (bus_wen && bus_waddr == WORD_AW'(WA_EN_CLR + b)) en_clr[b*32 +: 32] = bus_wdata & wmask;
            if (bus_wen && bus_waddr == WORD_AW'(WA_PD_SET + b)) pd_set[b*32 +: 32] = bus_wdata & wmask;
            if (bus_wen && bus_waddr == WORD_AW'(WA_PD_CLR + b)) pd_clr[b*32 +: 32] = bus_wdata & wmask;
        end
        for (int i = 0; i < N_LINES; i++) begin
            cfg_we[i]          = bus_wen && (bus_waddr == WORD_AW'(WA_CFG + i / 16))
                                 && bus_be[(2 * (i % 16) + 1) / 8];
            cfg_val[i]         = bus_wdata[2 * (i % 16) + 1];
            prio_we[i]         = bus_wen && (bus_waddr == WORD_AW'(WA_PRIO + i / 4))
                                 && bus_be[i % 4];
            prio_wd[i*8 +: 8]  = bus_wdata[8 * (i % 4) +: 8];
            ack_hit[i]         = ack_valid && (ack_id == ID_W'(i));
            eoi_hit[i]         = eoi_valid && (eoi_id == ID_W'(i));
        end
    end

    // control register
    always_comb begin
        st_d = st_q;
        if (bus_wen && bus_waddr == WA_CTRL && bus_be[0]) begin
            st_d.ctrl = ctrl_t'(bus_wdata[1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        dist_line_bank #(
            .BASE_ID (b * LINES_PER_BANK),
            .IMPL    (IMPL[b*32 +: 32])
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_i     (irq_in[b*32 +: 32]),
            .en_set_i  (en_set[b*32 +: 32]),
            .en_clr_i  (en_clr[b*32 +: 32]),
            .pd_set_i  (pd_set[b*32 +: 32]),
            .pd_clr_i  (pd_clr[b*32 +: 32]),
            .cfg_we_i  (cfg_we[b*32 +: 32]),
            .cfg_val_i (cfg_val[b*32 +: 32]),
            .ack_i     (ack_hit[b*32 +: 32]),
            .eoi_i     (eoi_hit[b*32 +: 32]),
            .en_o      (en_all[b*32 +: 32]),
            .pend_o    (pend_all[b*32 +: 32]),
            .act_o     (act_all[b*32 +: 32]),
            .edge_o    (edge_all[b*32 +: 32])
        );
    end

    dist_prio_array #(
        .N_LINES (N_LINES),
        .IMPL    (IMPL),
        .PRIO_W  (8)
    ) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (prio_we),
        .wdata_i (prio_wd),
        .prio_o  (prio_all)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_waddr == WA_CTRL) bus_rdata = {30'd0, st_q.ctrl};
        if (bus_waddr == WA_TYPE) bus_rdata = TYPE_WORD;
        for (int b = 0; b < NB; b++) begin
            if (bus_waddr == WORD_AW'(WA_EN_SET + b) || bus_waddr == WORD_AW'(WA_EN_CLR + b))
                bus_rdata = en_all[b*32 +: 32];
            if (bus_waddr == WORD_AW'(WA_PD_SET + b) || bus_waddr == WORD_AW'(WA_PD_CLR + b))
                bus_rdata = pend_all[b*32 +: 32];
            if (bus_waddr == WORD_AW'(WA_ACTIVE + b))
                bus_rdata = act_all[b*32 +: 32];
        end
        for (int w = 0; w < PRIO_WORDS; w++) begin
            if (bus_waddr == WORD_AW'(WA_PRIO + w)) bus_rdata = prio_all[w*32 +: 32];
        end
        for (int w = 0; w < CFG_WORDS; w++) begin
            if (bus_waddr == WORD_AW'(WA_CFG + w)) begin
                bus_rdata = '0;
                for (int k = 0; k < 16; k++) begin
                    bus_rdata[2*k+1] = edge_all[w*16 + k];
                end
            end
        end
    end

    assign fwd_en_o = st_q.ctrl.fwd_en;
    assign enab_o   = en_all;
    assign pend_o   = pend_all;
    assign prio_o   = prio_all;

endmodule

// File: rtl/dist_regs_chk.sv
module dist_regs_chk
    import dist_regs_pkg::*;
#(
    parameter int                 N_LINES = 64,
    parameter logic [N_LINES-1:0] IMPL    = '1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wen,
    input logic [9:0]             bus_waddr,
    input logic [3:0]             bus_be,
    input logic [31:0]            bus_wdata,
    input logic [N_LINES-1:0]     irq_in,
    input logic                   fwd_en_o,
    input logic [N_LINES-1:0]     enab_o,
    input logic [N_LINES-1:0]     pend_o,
    input logic [N_LINES*8-1:0]   prio_o,
    input logic [N_LINES-1:0]     edge_all
);

    localparam logic [9:0] CA_CTRL   = 10'(OFS_CTRL >> 2);
    localparam logic [9:0] CA_EN_SET = 10'(OFS_EN_SET >> 2);
    localparam logic [9:0] CA_EN_CLR = 10'(OFS_EN_CLR >> 2);
    localparam logic [9:0] CA_PRIO16 = 10'((OFS_PRIO >> 2) + 4);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2
    ctrl_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_waddr == CA_CTRL && bus_be[0]) |=> (fwd_en_o == $past(bus_wdata[0])));

    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_waddr == CA_EN_SET && bus_be == 4'hF)
        |=> ((enab_o[31:0] & $past(bus_wdata)) == ($past(bus_wdata) & IMPL[31:0])));

    // R5
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_waddr == CA_EN_CLR && bus_be == 4'hF)
        |=> ((enab_o[31:0] & $past(bus_wdata)) == 32'd0));

    // R6
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones((enab_o | pend_o) & ~IMPL) == 0);

    // R8
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (((pend_o ^ $past(irq_in)) & ~$past(edge_all) & IMPL) == '0));

    // R11
    prio_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_waddr == CA_PRIO16 && bus_be[0] && IMPL[16])
        |=> (prio_o[16*8 +: 8] == $past(bus_wdata[7:0])));

endmodule

bind dist_regs dist_regs_chk #(.N_LINES(N_LINES), .IMPL(IMPL)) u_chk (.*);

// File: tb/dist_regs_tb.sv
module dist_regs_tb;

    localparam int N     = 64;
    localparam int NCPU  = 2;
    localparam int NB    = N / 32;
    localparam logic [N-1:0] IMPL = 64'hFFFF_00FF_FFFF_FFFF;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wen = 1'b0;
    logic [9:0]     bus_waddr = '0;
    logic [3:0]     bus_be = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [N-1:0]   irq_in = '0;
    logic           ack_valid = 1'b0;
    logic [5:0]     ack_id = '0;
    logic           eoi_valid = 1'b0;
    logic [5:0]     eoi_id = '0;
    logic           fwd_en_o;
    logic [N-1:0]   enab_o, pend_o;
    logic [N*8-1:0] prio_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit       m_en[N];
    bit       m_pend[N];
    bit       m_act[N];
    bit       m_edge[N];
    bit       m_prev[N];
    bit [7:0] m_prio[N];
    bit [1:0] m_ctrl;

    logic [N-1:0]   e_en, e_pd;
    logic [N*8-1:0] e_pr;

    always #5 clk = ~clk;

    dist_regs #(.N_LINES(N), .N_CPUS(NCPU), .IMPL(IMPL)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_waddr(bus_waddr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .ack_valid(ack_valid), .ack_id(ack_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id), .fwd_en_o(fwd_en_o),
        .enab_o(enab_o), .pend_o(pend_o), .prio_o(prio_o)
    );

    task automatic chk(input string req, input logic [63:0] actual,
                       input logic [63:0] expv, input string what);
        checks++;
        if (actual !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, actual, expv);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0; m_prev[i] = 0; m_prio[i] = 0;
            m_edge[i] = (i < 16) && IMPL[i];
        end
        m_ctrl = 0;
    endtask

    function automatic bit hit(input int base, input int i);
        return bus_wen && (int'(bus_waddr) * 4 == base + 4 * (i / 32)) && bus_be[(i % 32) / 8];
    endfunction

    task automatic model_step();
        if (bus_wen && bus_waddr == 10'd0 && bus_be[0]) m_ctrl = bus_wdata[1:0];
        for (int i = 0; i < N; i++) begin
            if (IMPL[i]) begin
                bit wb, setc, clrc, ak, eo, old_edge;
                wb = bus_wdata[i % 32];
                old_edge = m_edge[i];
                if (hit(32'h100, i) && wb) m_en[i] = 1;
                if (hit(32'h180, i) && wb) m_en[i] = 0;
                if (i >= 16 && bus_wen && int'(bus_waddr) * 4 == 32'hC00 + 4 * (i / 16)
                    && bus_be[(2 * (i % 16) + 1) / 8])
                    m_edge[i] = bus_wdata[2 * (i % 16) + 1];
                if (bus_wen && int'(bus_waddr) * 4 == 32'h400 + (i / 4) * 4 && bus_be[i % 4])
                    m_prio[i] = bus_wdata[8 * (i % 4) +: 8];
                ak = ack_valid && int'(ack_id) == i;
                eo = eoi_valid && int'(eoi_id) == i;
                if (!old_edge) begin
                    m_pend[i] = irq_in[i];
                end else begin
                    setc = (irq_in[i] && !m_prev[i]) || (i >= 16 && hit(32'h200, i) && wb);
                    clrc = (i >= 16 && hit(32'h280, i) && wb) || ak;
                    if (setc) m_pend[i] = 1;
                    else if (clrc) m_pend[i] = 0;
                end
                if (ak) m_act[i] = 1;
                else if (eo) m_act[i] = 0;
            end
            m_prev[i] = irq_in[i];
        end
    endtask

    function automatic logic [31:0] exp_read(input int a);
        logic [31:0] r = '0;
        if (a == 0) r = {30'd0, m_ctrl};
        else if (a == 4) r = ((NCPU - 1) << 5) | (NB - 1);
        else if (a >= 32'h100 && a < 32'h100 + 4 * NB)
            for (int k = 0; k < 32; k++) r[k] = m_en[(a - 32'h100) / 4 * 32 + k];
        else if (a >= 32'h180 && a < 32'h180 + 4 * NB)
            for (int k = 0; k < 32; k++) r[k] = m_en[(a - 32'h180) / 4 * 32 + k];
        else if (a >= 32'h200 && a < 32'h200 + 4 * NB)
            for (int k = 0; k < 32; k++) r[k] = m_pend[(a - 32'h200) / 4 * 32 + k];
        else if (a >= 32'h280 && a < 32'h280 + 4 * NB)
            for (int k = 0; k < 32; k++) r[k] = m_pend[(a - 32'h280) / 4 * 32 + k];
        else if (a >= 32'h300 && a < 32'h300 + 4 * NB)
            for (int k = 0; k < 32; k++) r[k] = m_act[(a - 32'h300) / 4 * 32 + k];
        else if (a >= 32'h400 && a < 32'h400 + N)
            for (int k = 0; k < 4; k++) r[8*k +: 8] = m_prio[a - 32'h400 + k];
        else if (a >= 32'hC00 && a < 32'hC00 + N / 4)
            for (int k = 0; k < 16; k++) r[2*k+1] = m_edge[(a - 32'hC00) / 4 * 16 + k];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // R13: output vectors against the model on every cycle
    always @(negedge clk) begin
        int bad;
        bad = 0;
        for (int i = 0; i < N; i++) begin
            e_en[i] = m_en[i];
            e_pd[i] = m_pend[i];
            e_pr[i*8 +: 8] = m_prio[i];
            if (prio_o[i*8 +: 8] !== m_prio[i]) bad = i + 1;
        end
        chk("R13", enab_o, e_en, "enable vector");
        chk("R13", pend_o, e_pd, "pending vector");
        chk("R13", {63'd0, fwd_en_o}, {63'd0, m_ctrl[0]}, "forward enable");
        chk("R13", 64'(bad), 64'd0, "priority vector first bad line+1");
    end

    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wen = 1'b1; bus_waddr = 10'(a / 4); bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd_lit(input int a, input logic [31:0] expv, input string req);
        @(negedge clk);
        bus_wen = 1'b0; bus_waddr = 10'(a / 4);
        #1;
        chk(req, {32'd0, bus_rdata}, {32'd0, expv}, $sformatf("read 0x%03h", a));
        chk(req, {32'd0, bus_rdata}, {32'd0, exp_read(a)}, $sformatf("model read 0x%03h", a));
    endtask

    task automatic set_irq(input int i, input bit v);
        @(negedge clk);
        irq_in[i] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_lit(32'h000, 32'h0, "R1");
        rd_lit(32'h104, 32'h0, "R1");
        rd_lit(32'h410, 32'h0, "R1");
        rd_lit(32'hC00, 32'hAAAA_AAAA, "R1");
        rd_lit(32'hC04, 32'h0, "R1");

        // R2 control
        wr(32'h000, 32'h3, 4'h1);
        rd_lit(32'h000, 32'h3, "R2");
        wr(32'h000, 32'hFFFF_FFF0, 4'hF);
        rd_lit(32'h000, 32'h0, "R2");
        wr(32'h000, 32'h1, 4'h1);

        // R3 type register
        wr(32'h004, 32'hFFFF_FFFF, 4'hF);
        rd_lit(32'h004, 32'h21, "R3");

        // R4 R5 R6 enables
        wr(32'h100, 32'hFFFF_FFFF, 4'hF);
        wr(32'h104, 32'hFFFF_FFFF, 4'hF);
        rd_lit(32'h100, 32'hFFFF_FFFF, "R4");
        rd_lit(32'h104, 32'hFFFF_00FF, "R6");
        rd_lit(32'h184, 32'hFFFF_00FF, "R5");
        wr(32'h100, 32'h0, 4'hF);
        rd_lit(32'h100, 32'hFFFF_FFFF, "R4");
        wr(32'h180, 32'hFFFF_FFFF, 4'h1);
        rd_lit(32'h180, 32'hFFFF_FF00, "R5");

        // R11 priority
        wr(32'h410, 32'hA5C3_7E81, 4'b0101);
        rd_lit(32'h410, 32'h00C3_0081, "R11");
        wr(32'h43C, 32'hFFFF_FFFF, 4'hF);
        rd_lit(32'h43C, 32'hFFFF_FFFF, "R11");
        wr(32'h428, 32'hFFFF_FFFF, 4'hF);
        rd_lit(32'h428, 32'h0, "R6");

        // R12 mode
        wr(32'hC00, 32'h0, 4'hF);
        rd_lit(32'hC00, 32'hAAAA_AAAA, "R12");
        wr(32'hC04, 32'h0000_0A03, 4'hF);
        rd_lit(32'hC04, 32'h0000_0A02, "R12");

        // R8 level line 33
        set_irq(33, 1);
        @(negedge clk);
        chk("R8", {63'd0, pend_o[33]}, 64'd1, "level pending high");
        rd_lit(32'h204, 32'h2, "R8");
        set_irq(33, 0);
        @(negedge clk);
        chk("R8", {63'd0, pend_o[33]}, 64'd0, "level pending low");

        // R7 ignored pending writes
        wr(32'h204, 32'h4, 4'hF);
        rd_lit(32'h204, 32'h0, "R7");
        wr(32'h200, 32'h20, 4'hF);
        rd_lit(32'h200, 32'h0, "R7");

        // R9 edge line 20
        set_irq(20, 1);
        set_irq(20, 0);
        repeat (2) @(negedge clk);
        chk("R9", {63'd0, pend_o[20]}, 64'd1, "edge pending held");
        wr(32'h280, 32'h0010_0000, 4'hF);
        chk("R7", {63'd0, pend_o[20]}, 64'd0, "clear pending");
        wr(32'h200, 32'h0010_0000, 4'hF);
        chk("R7", {63'd0, pend_o[20]}, 64'd1, "set pending");

        // R10 acknowledge / end
        @(negedge clk); ack_valid = 1'b1; ack_id = 6'd20;
        @(negedge clk); ack_valid = 1'b0;
        chk("R10", {63'd0, pend_o[20]}, 64'd0, "ack clears pending");
        rd_lit(32'h300, 32'h0010_0000, "R10");
        @(negedge clk); ack_valid = 1'b1; ack_id = 6'd20; eoi_valid = 1'b1; eoi_id = 6'd20;
        @(negedge clk); ack_valid = 1'b0; eoi_valid = 1'b0;
        rd_lit(32'h300, 32'h0010_0000, "R10");
        @(negedge clk); eoi_valid = 1'b1; eoi_id = 6'd20;
        @(negedge clk); eoi_valid = 1'b0;
        rd_lit(32'h300, 32'h0, "R10");
        wr(32'h300, 32'hFFFF_FFFF, 4'hF);
        rd_lit(32'h300, 32'h0, "R10");

        // R9 rise and clear in the same cycle on line 21
        @(negedge clk);
        irq_in[21] = 1'b1;
        bus_wen = 1'b1; bus_waddr = 10'(32'h280 / 4); bus_wdata = 32'h0020_0000; bus_be = 4'hF;
        @(negedge clk);
        bus_wen = 1'b0;
        chk("R9", {63'd0, pend_o[21]}, 64'd1, "set wins over clear");
        irq_in[21] = 1'b0;

        // mixed traffic against the model
        for (int c = 0; c < 600; c++) begin
            int k, a;
            @(negedge clk);
            irq_in = {$urandom, $urandom} & {$urandom, $urandom};
            k = $urandom % 9;
            case (k)
                0: a = 0;
                1: a = 4;
                2: a = 32'h100 + 4 * ($urandom % NB);
                3: a = 32'h180 + 4 * ($urandom % NB);
                4: a = 32'h200 + 4 * ($urandom % NB);
                5: a = 32'h280 + 4 * ($urandom % NB);
                6: a = 32'h300 + 4 * ($urandom % NB);
                7: a = 32'h400 + 4 * ($urandom % (N / 4));
                default: a = 32'hC00 + 4 * ($urandom % (N / 16));
            endcase
            bus_waddr = 10'(a / 4);
            bus_wen   = ($urandom % 2) == 1;
            bus_wdata = $urandom;
            bus_be    = 4'($urandom);
            ack_valid = ($urandom % 4) == 0;
            ack_id    = 6'($urandom);
            eoi_valid = ($urandom % 4) == 0;
            eoi_id    = 6'($urandom);
            #1;
            chk("R4", {32'd0, bus_rdata}, {32'd0, exp_read(a)}, $sformatf("mixed read 0x%03h", a));
        end
        @(negedge clk);
        bus_wen = 1'b0; ack_valid = 1'b0; eoi_valid = 1'b0;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule